// File: doc/BRIEF.md
# Start-of-Frame Referenced Oscillator Trim Controller

This block keeps a free-running local oscillator close to the rate set by a USB host. It counts local clock cycles between successive start-of-frame strobes and compares the result with the nominal count for a 1 ms frame, which is 48000 cycles of a 48 MHz clock. It then moves a quantized trim code that picks one of a small set of discrete frequency bands for the oscillator. The correction only matches frequency. No phase detection is done, and a measurement counts as on target when it falls inside a tolerance window of about ±2500 ppm (±120 counts at the default size).

Each accepted measurement moves the trim code by at most one band, toward the target. The code stays put while the measurement is inside the window, and it saturates at the lowest and highest bands. A start-of-frame strobe that arrives after a gap longer than two nominal frames is treated as a missed frame. That measurement is discarded and a new one starts. When recovery is turned off, the trim code returns to its untrimmed centre band and the oscillator free-runs.

Top module: `sof_trim_ctrl`

## Requirements
- R1: While `rst` is high and on the cycle after it, `trim` equals TRIM_CENTER (2^(TRIM_W-1) by default) and `locked` is 0.
- R2: An interval is the number of `clk` rising edges from the edge that samples one `sof` pulse to the edge that samples the next. The first `sof` after reset or after `en` rises only starts a measurement and changes neither output.
- R3: When an interval N satisfies NOM_COUNT-TOL_COUNT <= N <= NOM_COUNT+TOL_COUNT, `trim` holds and `locked` becomes 1.
- R4: When NOM_COUNT+TOL_COUNT < N <= 2*NOM_COUNT (local clock fast), `trim` decreases by exactly one and `locked` becomes 0. A higher trim code means a faster oscillator.
- R5: When N < NOM_COUNT-TOL_COUNT (local clock slow), `trim` increases by exactly one and `locked` becomes 0.
- R6: `trim` saturates. A fast interval at code 0 leaves it at 0, and a slow interval at code 2^TRIM_W-1 leaves it there. The code never wraps, and it never changes by more than one per cycle.
- R7: An interval N > 2*NOM_COUNT is discarded. `trim` and `locked` stay unchanged, and the next interval is measured from that `sof`.
- R8: While `en` is 0, `trim` is TRIM_CENTER, `locked` is 0 and `sof` is ignored. After `en` rises, the first `sof` only starts a measurement.
- R9: `trim` and `locked` change only on the edge that samples an accepted `sof` (visible right after that edge), or in response to `en` or `rst`.
- R10: With an oscillator whose interval grows with the trim code, repeated frames drive the loop band by band to the first band inside the window, where it locks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local oscillator clock being trimmed |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Recovery enable; 0 forces the untrimmed centre band |
| sof | input | 1 | One-cycle start-of-frame strobe, synchronous to `clk` |
| trim | output | TRIM_W | Registered trim band code |
| locked | output | 1 | Registered indication that the last accepted interval was inside the window |

## Verification
A wrong count or a misplaced window edge shows up on `trim` and `locked` right after the `sof` edge that closes the affected interval, so every frame is a direct observation. The bench probes intervals one count on either side of each window bound and of the missed-frame limit. A stuck saturation or a wrap shows up as a jump across the code range within one frame of reaching either end. A stale arming flag or counter after disable shows up as a spurious step or lock on the first frame after `en` rises.

// File: rtl/sof_trim_pkg.sv
package sof_trim_pkg;
  typedef enum logic [2:0] {
    CLS_IDLE,
    CLS_INSIDE,
    CLS_FAST,
    CLS_SLOW,
    CLS_DROP
  } interval_cls_e;
endpackage

// File: rtl/sof_interval_counter.sv
module sof_interval_counter #(
  parameter int NOM_COUNT = 48000,
  parameter int CW        = $clog2(2*NOM_COUNT+2)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          sof,
  output logic          meas_valid,
  output logic          meas_over,
  output logic [CW-1:0] meas_len
);
  localparam logic [CW-1:0] CAP = CW'(2*NOM_COUNT);

  logic [CW-1:0] cnt_q;
  logic          armed_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (sof) begin
      cnt_q   <= '0;
      armed_q <= 1'b1;
    end else if (cnt_q != CAP) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  // the edge sampling sof is itself one of the counted edges
  assign meas_len   = cnt_q + CW'(1);
  assign meas_over  = (cnt_q == CAP);
  assign meas_valid = en && sof && armed_q;
endmodule

// File: rtl/sof_error_classifier.sv
module sof_error_classifier
  import sof_trim_pkg::*;
#(
  parameter int NOM_COUNT = 48000,
  parameter int TOL_COUNT = 120,
  parameter int CW        = $clog2(2*NOM_COUNT+2)
) (
  input  logic          meas_valid,
  input  logic          meas_over,
  input  logic [CW-1:0] meas_len,
  output interval_cls_e cls
);
  localparam logic [CW-1:0] HI_LIM = CW'(NOM_COUNT + TOL_COUNT);
  localparam logic [CW-1:0] LO_LIM = CW'(NOM_COUNT - TOL_COUNT);

  always_comb begin
    if (!meas_valid)            cls = CLS_IDLE;
    else if (meas_over)         cls = CLS_DROP;
    else if (meas_len > HI_LIM) cls = CLS_FAST;
    else if (meas_len < LO_LIM) cls = CLS_SLOW;
    else                        cls = CLS_INSIDE;
  end
endmodule

// File: rtl/sof_trim_stepper.sv
module sof_trim_stepper
  import sof_trim_pkg::*;
#(
  parameter int TRIM_W      = 6,
  parameter int TRIM_CENTER = 2**(TRIM_W-1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  interval_cls_e     cls,
  output logic [TRIM_W-1:0] trim,
  output logic              locked
);
  localparam logic [TRIM_W-1:0] CODE_MAX = '1;
  localparam logic [TRIM_W-1:0] CODE_MIN = '0;
  localparam logic [TRIM_W-1:0] CODE_MID = TRIM_W'(TRIM_CENTER);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      trim   <= CODE_MID;
      locked <= 1'b0;
    end else begin
      case (cls)
        CLS_INSIDE: locked <= 1'b1;
        CLS_FAST: begin
          locked <= 1'b0;
          if (trim != CODE_MIN) trim <= trim - TRIM_W'(1);
        end
        CLS_SLOW: begin
          locked <= 1'b0;
          if (trim != CODE_MAX) trim <= trim + TRIM_W'(1);
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sof_trim_ctrl.sv
module sof_trim_ctrl
  import sof_trim_pkg::*;
#(
  parameter int NOM_COUNT   = 48000,
  parameter int TOL_COUNT   = 120,
  parameter int TRIM_W      = 6,
  parameter int TRIM_CENTER = 2**(TRIM_W-1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              sof,
  output logic [TRIM_W-1:0] trim,
  output logic              locked
);
  localparam int CW = $clog2(2*NOM_COUNT+2);

  logic          meas_valid;
  logic          meas_over;
  logic [CW-1:0] meas_len;
  interval_cls_e cls;

  sof_interval_counter #(.NOM_COUNT(NOM_COUNT), .CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .en(en), .sof(sof),
    .meas_valid(meas_valid), .meas_over(meas_over), .meas_len(meas_len)
  );

  sof_error_classifier #(.NOM_COUNT(NOM_COUNT), .TOL_COUNT(TOL_COUNT), .CW(CW)) u_cls (
    .meas_valid(meas_valid), .meas_over(meas_over), .meas_len(meas_len), .cls(cls)
  );

  sof_trim_stepper #(.TRIM_W(TRIM_W), .TRIM_CENTER(TRIM_CENTER)) u_step (
    .clk(clk), .rst(rst), .en(en), .cls(cls), .trim(trim), .locked(locked)
  );
endmodule

// File: rtl/sof_trim_ctrl_chk.sv
module sof_trim_ctrl_chk #(
  parameter int TRIM_W      = 6,
  parameter int TRIM_CENTER = 2**(TRIM_W-1)
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic              sof,
  input logic [TRIM_W-1:0] trim,
  input logic              locked
);
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (trim == TRIM_W'(TRIM_CENTER) && !locked));

  p_quiet_between_frames_r9: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en) && !$past(sof) && !$past(rst)) |-> ($stable(trim) && $stable(locked)));

  p_single_step_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(en) && !$past(rst)) |->
      (int'(trim) <= int'($past(trim)) + 1 && int'(trim) + 1 >= int'($past(trim))));

  p_disabled_center_r8: assert property (@(posedge clk) disable iff (rst)
    !en |=> (trim == TRIM_W'(TRIM_CENTER) && !locked));

  p_lock_on_frame_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> ($past(sof) && $past(en)));
endmodule

bind sof_trim_ctrl sof_trim_ctrl_chk #(.TRIM_W(TRIM_W), .TRIM_CENTER(TRIM_CENTER)) u_chk (
  .clk(clk), .rst(rst), .en(en), .sof(sof), .trim(trim), .locked(locked)
);

// File: tb/tb_sof_trim_ctrl.sv
module tb_sof_trim_ctrl;
  localparam int NOM  = 960;
  localparam int TOL  = 24;
  localparam int TW   = 4;
  localparam int CTR  = 8;
  localparam int TMAX = 2**TW - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          en  = 1'b0;
  logic          sof = 1'b0;
  logic [TW-1:0] trim;
  logic          locked;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int  ref_trim  = CTR;
  bit  ref_lock  = 1'b0;
  bit  ref_armed = 1'b0;

  always #10 clk = ~clk;

  sof_trim_ctrl #(.NOM_COUNT(NOM), .TOL_COUNT(TOL), .TRIM_W(TW), .TRIM_CENTER(CTR)) dut (
    .clk(clk), .rst(rst), .en(en), .sof(sof), .trim(trim), .locked(locked)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // expected response to one interval, from the requirements
  task automatic ref_apply(input int n);
    if (!ref_armed) ref_armed = 1'b1;
    else if (n > 2*NOM) ;
    else if (n > NOM + TOL) begin ref_lock = 1'b0; if (ref_trim > 0) ref_trim--; end
    else if (n < NOM - TOL) begin ref_lock = 1'b0; if (ref_trim < TMAX) ref_trim++; end
    else ref_lock = 1'b1;
  endtask

  task automatic pulse(input int n);
    repeat (n-1) @(negedge clk);
    sof = 1'b1;
    @(negedge clk);
    sof = 1'b0;
  endtask

  task automatic frame(input int n, input string tag);
    pulse(n);
    ref_apply(n);
    chk(int'(trim) == ref_trim, tag, int'(trim), ref_trim);
    chk(locked == ref_lock, tag, int'(locked), int'(ref_lock));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(int'(trim) == CTR && !locked, "R1 reset state", int'(trim), CTR);
    rst = 1'b0;
    @(negedge clk);
    chk(int'(trim) == CTR && !locked, "R1 after reset", int'(trim), CTR);
    en = 1'b1;

    // R2: first strobe only arms
    frame(500, "R2 arming strobe");
    frame(NOM, "R3 nominal interval");
    frame(NOM + TOL, "R3 upper window edge");
    frame(NOM - TOL, "R3 lower window edge");
    frame(NOM + TOL + 1, "R4 just above window");
    frame(NOM - TOL - 1, "R5 just below window");
    frame(2*NOM, "R4 longest accepted interval");

    // near-exhaustive sweep around the window
    for (int off = -48; off <= 48; off += 6) frame(NOM + off, "R3/R4/R5 sweep");

    // R6 saturation at the top and the bottom
    for (int i = 0; i < TMAX + 3; i++) frame(NOM - 100, "R6 climb to max");
    chk(int'(trim) == TMAX, "R6 top saturation", int'(trim), TMAX);
    for (int i = 0; i < TMAX + 3; i++) frame(NOM + 100, "R6 fall to min");
    chk(int'(trim) == 0, "R6 bottom saturation", int'(trim), 0);
    frame(NOM - 30, "R5 step up from min");

    // R7 missed frame, then measurement restarts from it
    frame(NOM, "R3 relock before gap");
    frame(2*NOM + 1, "R7 discarded long gap");
    frame(NOM, "R7 restart from discarded strobe");
    frame(2*NOM + 400, "R7 discarded very long gap");
    frame(NOM + 40, "R7 restart then fast step");

    // R9: outputs stay until the sampling edge, then update
    begin
      int old_t;
      old_t = int'(trim);
      repeat (NOM - 101) @(negedge clk);
      sof = 1'b1;
      chk(int'(trim) == old_t, "R9 no change before edge", int'(trim), old_t);
      @(negedge clk);
      sof = 1'b0;
      ref_apply(NOM - 100);
      chk(int'(trim) == ref_trim, "R9 change after edge", int'(trim), ref_trim);
    end

    // R8 disable
    en = 1'b0;
    @(negedge clk);
    chk(int'(trim) == CTR && !locked, "R8 disable to centre", int'(trim), CTR);
    pulse(NOM - 200);
    chk(int'(trim) == CTR && !locked, "R8 strobe ignored while off", int'(trim), CTR);
    en = 1'b1;
    ref_trim = CTR; ref_lock = 1'b0; ref_armed = 1'b0;
    frame(NOM - 200, "R8 first strobe after enable arms only");
    frame(NOM, "R8 lock after re-arm");

    // R10 closed loop with a trim-dependent oscillator model
    begin
      int offs, k, exp_band;
      offs = 75; k = 10; exp_band = CTR;
      while (offs + k*(exp_band - CTR) > TOL && exp_band > 0) exp_band--;
      for (int i = 0; i < 12; i++) begin
        int n;
        n = NOM + offs + k*(int'(trim) - CTR);
        frame(n, "R10 loop frame");
      end
      chk(int'(trim) == exp_band, "R10 settled band", int'(trim), exp_band);
      chk(locked == 1'b1, "R10 locked", int'(locked), 1);
    end

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule